// File: doc/BRIEF.md
# Serial Interrupt Line Agent

This block is the peripheral end of a shared, open-drain serial interrupt line. Every agent on the line and the host run from the same bus clock. The host opens each cycle with a long low pulse. The block measures that pulse and then counts the three-clock frames that follow, so it knows which frame is on the line at each clock. For each of its interrupt inputs it holds a frame number. In that input's frame it reports the input's level: a low during the sample clock, a high during the recovery clock, and the line released at turnaround.

The host closes a cycle with a short low pulse, and the width of that pulse selects the mode for the idle time that follows. In quiet mode the block may start a cycle itself. It pulls the line low for a single clock when one of its inputs differs from the level it last reported, and the host then continues the pulse. In continuous mode the block waits for the host to start every cycle.

Top module: `sirq_agent`

## Requirements
- R1: After reset `serOe` is 0 and the block is in continuous mode, so it drives nothing while idle, whatever its inputs are.
- R2: Suppose the line was sampled low for between START_MIN (4) and START_MAX (8) consecutive clocks and is then sampled high. That high clock is the turnaround of the start frame, and the next clock is the sample clock of frame 0.
- R3: A low run sampled as shorter than 4 clocks or longer than 8 clocks starts no cycle. Inside a cycle, a low run of one clock (a report from any agent) does not disturb the frame count.
- R4: Frame f occupies clocks 3f, 3f+1 and 3f+2 after the start turnaround, in the order sample, recovery, turnaround. Take a source i with `irqFrame[i]` equal to f and `irqIn[i]` equal to 1 at the edge that opens the sample clock. For that source the block gives `serOe`=1 and `serOut`=0 in the sample clock, `serOe`=1 and `serOut`=1 in the recovery clock, and `serOe`=0 in the turnaround clock.
- R5: In a frame that holds no active source, `serOe` stays 0 for all three clocks.
- R6: Inside a cycle, a low run of 2 or 3 clocks ends the cycle, and no frame is driven until the next start. Width 2 selects quiet mode and width 3 selects continuous mode.
- R7: The block requests a cycle when all of the following hold: it is idle in quiet mode, the line has been sampled high at the last two edges, and some source differs from the level last reported in its frame. The request is `serOe`=1 with `serOut`=0 for exactly one clock, starting the clock after the change is sampled.
- R8: In continuous mode the block never requests a cycle.
- R9: The block makes at most one request per idle period. Another request is possible only after the next start has been detected.
- R10: Each source's last reported level is updated in its sample clock, whether the source was active or inactive. No request is made while every source equals its reported level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock shared by all agents on the line |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Sampled level of the shared line |
| serOe | output | 1 | Line drive enable |
| serOut | output | 1 | Level driven while `serOe` is 1 |
| irqIn | input | NUM_SRC | Interrupt inputs, 1 = active |
| irqFrame | input | NUM_SRC x FRAME_W | Frame number assigned to each interrupt input |

## Verification
A frame counter that is one position off shows up at the ports in the same cycle. The report moves into the frame next to the assigned one, or a high appears in a turnaround clock, within three clocks of the start pulse. A wrong mode or a stale reported level shows two clocks after the stop pulse ends: a low appears on an idle line that should stay quiet, or an expected one-clock request is missing. The sweep walks every input pattern through a full cycle and compares each clock of each frame, so an error in the counting or in the recovery drive is caught on the clock where it occurs.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2
  } phase_e;

  // strobes from control to datapath, each describing the coming clock
  typedef struct packed {
    logic startSeen;
    logic enterSample;
    logic enterRecover;
    logic quietIdle;
  } ctlStrobe_t;

endpackage

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
#(
  parameter int FRAME_W   = 5,
  parameter int START_MIN = 4,
  parameter int START_MAX = 8,
  parameter int CNT_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serIn,
  output ctlStrobe_t         strb,
  output logic [FRAME_W-1:0] nextFrame,
  output logic               active,
  output logic               quiet,
  output phase_e             phase
);

  localparam logic [CNT_W-1:0]   CNT_MAX    = '1;
  localparam logic [FRAME_W-1:0] FRAME_LAST = '1;
  localparam logic [CNT_W-1:0]   WID_MIN    = CNT_W'(START_MIN);
  localparam logic [CNT_W-1:0]   WID_MAX    = CNT_W'(START_MAX);
  localparam logic [CNT_W-1:0]   STOP_QUIET = CNT_W'(2);
  localparam logic [CNT_W-1:0]   STOP_CONT  = CNT_W'(3);

  logic               prevIn;
  logic [CNT_W-1:0]   lowCnt;
  logic [FRAME_W-1:0] frame;
  logic               rise;
  logic               startDet;
  logic               stopDet;
  logic               lastFrame;

  // pulse width is judged on the first high sample after a low run
  assign rise      = serIn && !prevIn;
  assign startDet  = rise && (lowCnt >= WID_MIN) && (lowCnt <= WID_MAX);
  assign stopDet   = rise && active && !startDet &&
                     ((lowCnt == STOP_QUIET) || (lowCnt == STOP_CONT));
  assign lastFrame = (frame == FRAME_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn <= 1'b1;
      lowCnt <= '0;
      active <= 1'b0;
      quiet  <= 1'b0;
      phase  <= PH_TURN;
      frame  <= '0;
    end else begin
      prevIn <= serIn;
      if (serIn)
        lowCnt <= '0;
      else if (lowCnt != CNT_MAX)
        lowCnt <= lowCnt + CNT_W'(1);

      if (startDet) begin
        active <= 1'b1;
        frame  <= '0;
        phase  <= PH_SAMPLE;
      end else if (stopDet) begin
        active <= 1'b0;
        quiet  <= (lowCnt == STOP_QUIET);
        phase  <= PH_TURN;
      end else if (active) begin
        unique case (phase)
          PH_SAMPLE:  phase <= PH_RECOVER;
          PH_RECOVER: phase <= PH_TURN;
          default: begin
            phase <= PH_SAMPLE;
            if (!lastFrame)
              frame <= frame + FRAME_W'(1);
          end
        endcase
      end
    end
  end

  always_comb begin
    strb.startSeen    = startDet;
    strb.enterSample  = startDet ||
                        (active && !stopDet && (phase == PH_TURN) && !lastFrame);
    strb.enterRecover = active && !startDet && !stopDet && (phase == PH_SAMPLE);
    strb.quietIdle    = !active && quiet && serIn && prevIn;
    nextFrame         = startDet ? '0 : (frame + FRAME_W'(1));
  end

endmodule

// File: rtl/sirq_dpath.sv
module sirq_dpath
  import sirq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int FRAME_W = 5
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctlStrobe_t                      strb,
  input  logic [FRAME_W-1:0]              nextFrame,
  input  logic [NUM_SRC-1:0]              irqIn,
  input  logic [NUM_SRC-1:0][FRAME_W-1:0] irqFrame,
  output logic                            serOe,
  output logic                            serOut
);

  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] lastRep;
  logic               pending;
  logic               drvLow;
  logic               drvHigh;
  logic               reqLow;
  logic               reqDone;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_match
    assign hit[i] = (irqFrame[i] == nextFrame);
  end

  assign pending = |(irqIn ^ lastRep);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastRep <= '0;
    end else if (strb.enterSample) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (hit[i]) lastRep[i] <= irqIn[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvLow  <= 1'b0;
      drvHigh <= 1'b0;
      reqLow  <= 1'b0;
      reqDone <= 1'b0;
    end else begin
      drvLow  <= strb.enterSample && |(hit & irqIn);
      drvHigh <= strb.enterRecover && drvLow;
      reqLow  <= strb.quietIdle && pending && !reqDone && !reqLow;
      if (strb.startSeen)
        reqDone <= 1'b0;
      else if (reqLow)
        reqDone <= 1'b1;
    end
  end

  assign serOe  = drvLow || drvHigh || reqLow;
  assign serOut = drvHigh;

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int FRAME_W   = 5,
  parameter int START_MIN = 4,
  parameter int START_MAX = 8,
  parameter int CNT_W     = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            serIn,
  output logic                            serOe,
  output logic                            serOut,
  input  logic [NUM_SRC-1:0]              irqIn,
  input  logic [NUM_SRC-1:0][FRAME_W-1:0] irqFrame
);

  ctlStrobe_t         strb;
  logic [FRAME_W-1:0] nextFrame;
  logic               cycleActive;
  logic               quietMode;
  phase_e             curPhase;
  logic               inTurn;

  assign inTurn = (curPhase == PH_TURN);

  sirq_ctrl #(
    .FRAME_W  (FRAME_W),
    .START_MIN(START_MIN),
    .START_MAX(START_MAX),
    .CNT_W    (CNT_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .serIn    (serIn),
    .strb     (strb),
    .nextFrame(nextFrame),
    .active   (cycleActive),
    .quiet    (quietMode),
    .phase    (curPhase)
  );

  sirq_dpath #(
    .NUM_SRC(NUM_SRC),
    .FRAME_W(FRAME_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .nextFrame(nextFrame),
    .irqIn    (irqIn),
    .irqFrame (irqFrame),
    .serOe    (serOe),
    .serOut   (serOut)
  );

endmodule

// File: rtl/sirq_agent_chk.sv
module sirq_agent_chk (
  input logic clk,
  input logic rstN,
  input logic serOe,
  input logic serOut,
  input logic cycleActive,
  input logic quietMode,
  input logic inTurn
);

  // R4
  recover_after_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serOe && serOut) |-> $past(serOe && !serOut));

  // R4
  turn_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleActive && inTurn) |-> !serOe);

  // R8
  cont_idle_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cycleActive && !quietMode) |-> !serOe);

  // R7
  request_one_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serOe && !serOut && !cycleActive) |=> (cycleActive || !serOe));

endmodule

bind sirq_agent sirq_agent_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .serOe      (serOe),
  .serOut     (serOut),
  .cycleActive(cycleActive),
  .quietMode  (quietMode),
  .inTurn     (inTurn)
);

// File: tb/test_sirq_agent.sv
module test_sirq_agent;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 4;
  localparam int FW         = 5;
  localparam int NF         = 9;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     hostHigh = 1'b1;
  logic [NSRC-1:0]          irqIn = '0;
  logic [NSRC-1:0][FW-1:0]  irqFrame;
  logic                     serOe;
  logic                     serOut;
  logic                     serIn;
  int                       checks = 0;
  int                       errors = 0;
  bit                       done = 1'b0;

  assign serIn = hostHigh && !(serOe && !serOut);

  always #(CLK_PERIOD/2) clk = ~clk;

  sirq_agent #(.NUM_SRC(NSRC), .FRAME_W(FW)) i_sirq_agent (
    .clk     (clk),
    .rstN    (rstN),
    .serIn   (serIn),
    .serOe   (serOe),
    .serOut  (serOut),
    .irqIn   (irqIn),
    .irqFrame(irqFrame)
  );

  task automatic chk(string req, logic [1:0] expv);
    logic [1:0] act;
    act = {serOe, serOe & serOut};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [1:0] expDrive(int k, logic [NSRC-1:0] pat);
    int  f;
    int  ph;
    bit  hit;
    f   = k / 3;
    ph  = k % 3;
    hit = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (irqFrame[i] == FW'(f) && pat[i]) hit = 1'b1;
    if (!hit || ph == 2) return 2'b00;
    return {1'b1, ph == 1};
  endfunction

  task automatic step(bit v);
    @(negedge clk);
    hostHigh = v;
  endtask

  task automatic doStart(int w);
    repeat (w) step(1'b0);
    step(1'b1);
  endtask

  // other agents report in frames 0 and 5 (never assigned here), R3
  task automatic doFrames(logic [NSRC-1:0] pat);
    for (int k = 0; k < 3*NF; k++) begin
      logic [1:0] e;
      step(!(k == 0 || k == 15));
      e = expDrive(k, pat);
      chk(e != 2'b00 ? "R4" : (k < 3 ? "R2" : "R5"), e);
    end
  endtask

  task automatic doStop(int w);
    repeat (w) begin
      step(1'b0);
      chk("R6", 2'b00);
    end
    step(1'b1);
    chk("R6", 2'b00);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    irqFrame[0] = FW'(1);
    irqFrame[1] = FW'(3);
    irqFrame[2] = FW'(4);
    irqFrame[3] = FW'(7);
    repeat (3) @(negedge clk);
    chk("R1", 2'b00);
    rstN = 1'b1;

    // R1 R8: continuous after reset, a changed input makes no request
    irqIn = 4'b0101;
    repeat (8) begin step(1'b1); chk("R8", 2'b00); end

    // R3: too short and too long low runs start nothing
    repeat (3) step(1'b0);
    repeat (12) begin step(1'b1); chk("R3", 2'b00); end
    repeat (9) step(1'b0);
    repeat (12) begin step(1'b1); chk("R3", 2'b00); end

    // R2 R4 R5: every input pattern, every start width
    for (int p = 0; p < 16; p++) begin
      irqIn = NSRC'(p);
      doStart(4 + p % 5);
      doFrames(NSRC'(p));
      doStop(3);
      step(1'b1);
      chk("R6", 2'b00);
    end

    // R6: quiet stop, R10: unchanged inputs give no request
    irqIn = 4'b0110;
    doStart(5);
    doFrames(4'b0110);
    doStop(2);
    step(1'b1);
    chk("R6", 2'b00);
    repeat (6) begin step(1'b1); chk("R10", 2'b00); end

    // R7: one-clock request, R9: no repeat while host ignores it
    step(1'b1);
    irqIn = 4'b0111;
    chk("R7", 2'b00);
    step(1'b1);
    chk("R7", 2'b10);
    step(1'b1);
    chk("R7", 2'b00);
    repeat (6) begin step(1'b1); chk("R9", 2'b00); end

    doStart(4);
    doFrames(4'b0111);
    doStop(2);
    step(1'b1);
    chk("R6", 2'b00);

    // R7: falling source requests, host stretches it into a start
    step(1'b1);
    irqIn = 4'b0011;
    step(1'b1);
    chk("R7", 2'b10);
    repeat (3) begin step(1'b0); chk("R7", 2'b00); end
    step(1'b1);
    doFrames(4'b0011);
    doStop(3);
    step(1'b1);
    chk("R6", 2'b00);

    // R8: continuous again, no request
    irqIn = 4'b1111;
    repeat (8) begin step(1'b1); chk("R8", 2'b00); end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule